// File: doc/BRIEF.md
# Two-Privilege Interrupt Selector

This block picks the next interrupt for a core that runs at machine or supervisor privilege. Each of N level-sensitive pending lines has its own settings, loaded through a small write port: an enable bit, a 2-bit target-mode code and an 8-bit level. The block combines those settings with the current privilege, the two global enables and one level threshold per target mode. From these it decides whether a trap should be requested, which privilege the trap targets, and which line wins.

The selection is made in two pools, one per target mode. A machine-target winner always beats any supervisor-target candidate. Within a pool, the higher level wins, and on equal levels the lower index wins. A separate wakeup output tells wait-for-interrupt logic that some enabled line is pending, even when the gating blocks the trap. All results are registered once, so they follow the inputs sampled at the previous clock edge.

Trap entry, status stacking and return handling belong to the core. The core is expected to drop the pending line or change the enables once it has taken the trap.

Top module: `irq_sel_top`

## Requirements
- R1: Mode code 2'b11 makes a line machine-target and 2'b01 makes it supervisor-target. A line with code 2'b00 or 2'b10 is never selected.
- R2: A line whose enable bit is 0 is never selected and does not raise the wakeup, even when its pending input is high.
- R3: At supervisor privilege (priv_m_i=0), an eligible machine-target line is taken whatever mie_i is.
- R4: At machine privilege (priv_m_i=1), a machine-target line is taken only when mie_i=1.
- R5: A supervisor-target line is never taken at machine privilege, whatever sie_i is.
- R6: At supervisor privilege, a supervisor-target line is taken only when sie_i=1.
- R7: Within one target mode, the eligible line with the highest level wins. On equal levels, the lower index wins.
- R8: Any eligible machine-target line wins over every supervisor-target line, whatever their levels.
- R9: A line is eligible only if its level is strictly greater than the threshold of its target mode: mthr_i for machine-target lines, sthr_i for supervisor-target lines.
- R10: A pending line that stays high is requested again as soon as the gating allows it. Nothing is latched: a pending line that is dropped is no longer requested.
- R11: wake_o is 1 when any enabled line is pending. This holds regardless of privilege, global enables, thresholds and mode code.
- R12: When take_o=1, idx_o is the winning index, cause_o is that index zero-extended, and lvl_o is its level. The software interrupt sits on index 3 and the timer on index 7. When take_o=0, tgt_m_o, idx_o, cause_o and lvl_o are 0.
- R13: All outputs are registered: they reflect the inputs and settings present just before the previous rising edge, and are 0 during reset. A settings write is applied at the clock edge on which cfg_we_i is high. After reset, every line has enable 0, mode 2'b11 and level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for one line's settings |
| cfg_idx_i | input | IDX_W | Index of the line being written |
| cfg_ie_i | input | 1 | Enable bit to write |
| cfg_mode_i | input | 2 | Target-mode code to write |
| cfg_lvl_i | input | 8 | Level to write |
| pend_i | input | N_IRQ | Level-sensitive pending lines |
| priv_m_i | input | 1 | Current privilege: 1 machine, 0 supervisor |
| mie_i | input | 1 | Machine global enable |
| sie_i | input | 1 | Supervisor global enable |
| mthr_i | input | 8 | Machine-target level threshold |
| sthr_i | input | 8 | Supervisor-target level threshold |
| take_o | output | 1 | Interrupt request to the core |
| tgt_m_o | output | 1 | Target of the request: 1 machine, 0 supervisor |
| idx_o | output | IDX_W | Winning line index |
| cause_o | output | CAUSE_W | Cause code of the winner |
| lvl_o | output | 8 | Level of the winner |
| wake_o | output | 1 | Wakeup for wait-for-interrupt |

## Verification
The bench builds the block with N_IRQ=8 and CAUSE_W=12. At that size, all 256 pending patterns can be crossed with every combination of privilege and the two global enables, under several threshold pairs and two full settings maps. The first map mixes machine-target, supervisor-target and reserved codes, and includes a level tie and a disabled line. The second map places the software interrupt on index 3 as supervisor-target at maximum level and the timer on index 7 as machine-target at minimum level. This brings every priority, gating and tie-break case within reach. Directed sequences add the one-cycle output delay, the reset state, and a line that stays pending and is requested again.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int LVL_W = 8;
  localparam logic [1:0] MODE_M = 2'b11;
  localparam logic [1:0] MODE_S = 2'b01;

  typedef struct packed {
    logic             ie;
    logic [1:0]       mode;
    logic [LVL_W-1:0] lvl;
  } irq_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  irq_cfg_t         wdata_i,
  output irq_cfg_t         cfg_o [N_IRQ]
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g] <= '{ie: 1'b0, mode: MODE_M, lvl: '0};
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        cfg_o[g] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  irq_cfg_t         cfg_i [N_IRQ],
  input  logic [N_IRQ-1:0] pend_i,
  input  logic             priv_m_i,
  input  logic             mie_i,
  input  logic             sie_i,
  input  logic [LVL_W-1:0] mthr_i,
  input  logic [LVL_W-1:0] sthr_i,
  output logic [N_IRQ-1:0] elig_m_o,
  output logic [N_IRQ-1:0] elig_s_o,
  output logic             wake_o
);
  logic m_open, s_open;
  logic [N_IRQ-1:0] live;

  // machine-target: always open below machine level, else needs mie
  assign m_open = !priv_m_i || mie_i;
  // supervisor-target: only while at supervisor level with sie
  assign s_open = !priv_m_i && sie_i;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign live[g]     = pend_i[g] && cfg_i[g].ie;
    assign elig_m_o[g] = live[g] && m_open && (cfg_i[g].mode == MODE_M) && (cfg_i[g].lvl > mthr_i);
    assign elig_s_o[g] = live[g] && s_open && (cfg_i[g].mode == MODE_S) && (cfg_i[g].lvl > sthr_i);
  end

  assign wake_o = |live;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] vld_i,
  input  logic [LVL_W-1:0] lvl_i [N_IRQ],
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LVL_W-1:0] lvl_o
);
  // strict compare keeps the lower index on ties
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (vld_i[i] && (!any_o || (lvl_i[i] > lvl_o))) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ   = 8,
  parameter int CAUSE_W = 12,
  localparam int IDX_W  = $clog2(N_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_ie_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic [LVL_W-1:0]   cfg_lvl_i,
  input  logic [N_IRQ-1:0]   pend_i,
  input  logic               priv_m_i,
  input  logic               mie_i,
  input  logic               sie_i,
  input  logic [LVL_W-1:0]   mthr_i,
  input  logic [LVL_W-1:0]   sthr_i,
  output logic               take_o,
  output logic               tgt_m_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic               wake_o
);
  irq_cfg_t         cfg [N_IRQ];
  irq_cfg_t         wdata;
  logic [LVL_W-1:0] lvl_vec [N_IRQ];
  logic [N_IRQ-1:0] elig_m, elig_s;
  logic             wake_d;
  logic             m_any, s_any;
  logic [IDX_W-1:0] m_idx, s_idx;
  logic [LVL_W-1:0] m_lvl, s_lvl;

  assign wdata = '{ie: cfg_ie_i, mode: cfg_mode_i, lvl: cfg_lvl_i};

  irq_cfg_regs #(.N_IRQ(N_IRQ)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
    .wdata_i(wdata), .cfg_o(cfg)
  );

  for (genvar g = 0; g < N_IRQ; g++) begin : g_lvl
    assign lvl_vec[g] = cfg[g].lvl;
  end

  irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .cfg_i(cfg), .pend_i(pend_i), .priv_m_i(priv_m_i), .mie_i(mie_i), .sie_i(sie_i),
    .mthr_i(mthr_i), .sthr_i(sthr_i), .elig_m_o(elig_m), .elig_s_o(elig_s), .wake_o(wake_d)
  );

  irq_arb #(.N_IRQ(N_IRQ)) u_arb_m (
    .vld_i(elig_m), .lvl_i(lvl_vec), .any_o(m_any), .idx_o(m_idx), .lvl_o(m_lvl)
  );

  irq_arb #(.N_IRQ(N_IRQ)) u_arb_s (
    .vld_i(elig_s), .lvl_i(lvl_vec), .any_o(s_any), .idx_o(s_idx), .lvl_o(s_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o  <= 1'b0;
      tgt_m_o <= 1'b0;
      idx_o   <= '0;
      cause_o <= '0;
      lvl_o   <= '0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= wake_d;
      take_o <= m_any || s_any;
      if (m_any) begin
        tgt_m_o <= 1'b1;
        idx_o   <= m_idx;
        cause_o <= CAUSE_W'(m_idx);
        lvl_o   <= m_lvl;
      end else if (s_any) begin
        tgt_m_o <= 1'b0;
        idx_o   <= s_idx;
        cause_o <= CAUSE_W'(s_idx);
        lvl_o   <= s_lvl;
      end else begin
        tgt_m_o <= 1'b0;
        idx_o   <= '0;
        cause_o <= '0;
        lvl_o   <= '0;
      end
    end
  end

  assert_m_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && tgt_m_o) |-> $past(mie_i || !priv_m_i));

  assert_s_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !tgt_m_o) |-> $past(sie_i && !priv_m_i));

  assert_s_thr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !tgt_m_o) |-> (lvl_o > $past(sthr_i)));

  assert_m_thr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && tgt_m_o) |-> (lvl_o > $past(mthr_i)));

  assert_take_wakes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> wake_o);

  assert_idle_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (!tgt_m_o && idx_o == '0 && lvl_o == '0));
endmodule

// File: tb/sim_irq_sel_top.sv
`timescale 1ns/1ps
module sim_irq_sel_top;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [IW-1:0] widx = '0;
  logic wie = 1'b0;
  logic [1:0] wmode = '0;
  logic [7:0] wlvl = '0;
  logic [N-1:0] pend = '0;
  logic privm = 1'b1, mie = 1'b0, sie = 1'b0;
  logic [7:0] mthr = '0, sthr = '0;
  logic take, tgtm, wake;
  logic [IW-1:0] idx;
  logic [CW-1:0] cause;
  logic [7:0] lvl;

  int n_chk = 0, n_fail = 0;
  logic b_ie [N];
  logic [1:0] b_mode [N];
  logic [7:0] b_lvl [N];

  always #2.5 clk = ~clk;

  irq_sel_top #(.N_IRQ(N), .CAUSE_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_idx_i(widx), .cfg_ie_i(wie),
    .cfg_mode_i(wmode), .cfg_lvl_i(wlvl), .pend_i(pend), .priv_m_i(privm),
    .mie_i(mie), .sie_i(sie), .mthr_i(mthr), .sthr_i(sthr), .take_o(take),
    .tgt_m_o(tgtm), .idx_o(idx), .cause_o(cause), .lvl_o(lvl), .wake_o(wake)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(output logic t, output logic m, output int ix, output int lv, output logic w);
    int bm = -1, bs = -1;
    w = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && b_ie[i]) begin
        w = 1'b1;
        if (b_mode[i] == 2'b11 && b_lvl[i] > mthr && (!privm || mie))
          if (bm < 0 || b_lvl[i] > b_lvl[bm]) bm = i;
        if (b_mode[i] == 2'b01 && b_lvl[i] > sthr && !privm && sie)
          if (bs < 0 || b_lvl[i] > b_lvl[bs]) bs = i;
      end
    end
    t = 1'b0; m = 1'b0; ix = 0; lv = 0;
    if (bm >= 0) begin t = 1'b1; m = 1'b1; ix = bm; lv = b_lvl[bm]; end
    else if (bs >= 0) begin t = 1'b1; ix = bs; lv = b_lvl[bs]; end
  endtask

  // drive at negedge, result visible after the next posedge
  task automatic step_chk(input string tag);
    logic t, m, w;
    int ix, lv;
    model(t, m, ix, lv, w);
    @(negedge clk);
    chk(tag, "take", int'(take), int'(t));
    chk(tag, "tgt_m", int'(tgtm), int'(m));
    chk(tag, "idx", int'(idx), ix);
    chk(tag, "cause", int'(cause), ix);
    chk(tag, "lvl", int'(lvl), lv);
    chk(tag, "wake", int'(wake), int'(w));
  endtask

  task automatic wr(input int i, input logic e, input logic [1:0] md, input logic [7:0] lv);
    we = 1'b1; widx = IW'(i); wie = e; wmode = md; wlvl = lv;
    @(negedge clk);
    we = 1'b0;
    b_ie[i] = e; b_mode[i] = md; b_lvl[i] = lv;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic sweep(input string tag);
    for (int th = 0; th < 3; th++) begin
      mthr = (th == 0) ? 8'd0 : (th == 1) ? 8'd100 : 8'd250;
      sthr = (th == 0) ? 8'd0 : (th == 1) ? 8'd50 : 8'd200;
      for (int c = 0; c < 8; c++) begin
        privm = c[0]; mie = c[1]; sie = c[2];
        for (int p = 0; p < 256; p++) begin
          pend = N'(p);
          step_chk(tag);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin b_ie[i] = 1'b0; b_mode[i] = 2'b11; b_lvl[i] = 8'd0; end
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "take in reset", int'(take), 0);
    chk("R13", "wake in reset", int'(wake), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pend = '1; privm = 1'b0; mie = 1'b1; sie = 1'b1;
    // R13: reset settings disable all lines
    step_chk("R13");
    chk("R13", "wake after reset config", int'(wake), 0);

    // R2: enabled-0 line ignored
    wr(3, 1'b0, 2'b01, 8'd200);
    pend = 8'h08;
    step_chk("R2");
    chk("R2", "no take disabled", int'(take), 0);

    // R1: reserved mode codes never taken, still wake
    wr(2, 1'b1, 2'b00, 8'd90);
    wr(4, 1'b1, 2'b10, 8'd90);
    pend = 8'h14;
    step_chk("R1");
    chk("R1", "reserved no take", int'(take), 0);
    chk("R11", "reserved wakes", int'(wake), 1);

    // R12 + R8: software idx3 supervisor max, timer idx7 machine min
    wr(3, 1'b1, 2'b01, 8'd255);
    wr(7, 1'b1, 2'b11, 8'd1);
    pend = 8'h88; privm = 1'b0; mie = 1'b0; sie = 1'b1; mthr = 0; sthr = 0;
    step_chk("R8");
    chk("R12", "timer cause", int'(cause), 7);
    chk("R3", "machine taken at S with mie=0", int'(tgtm), 1);
    // R13: output holds until next edge
    pend = 8'h08;
    #1 chk("R13", "registered hold", int'(cause), 7);
    step_chk("R12");
    chk("R12", "software cause", int'(cause), 3);
    // R5: at machine level supervisor target blocked
    privm = 1'b1; mie = 1'b1;
    step_chk("R5");
    chk("R5", "no S take at M", int'(take), 0);
    // R6 + R10: sie low blocks, re-raise re-requests
    privm = 1'b0; sie = 1'b0;
    step_chk("R6");
    sie = 1'b1;
    step_chk("R10");
    chk("R10", "re-request", int'(take), 1);
    pend = 8'h00;
    step_chk("R10");
    // R4: timer at machine level needs mie
    pend = 8'h80; privm = 1'b1; mie = 1'b0;
    step_chk("R4");
    chk("R4", "blocked mie=0", int'(take), 0);
    chk("R11", "wake while blocked", int'(wake), 1);
    mie = 1'b1;
    step_chk("R4");
    // R9: strict threshold
    sthr = 8'd255; privm = 1'b0; pend = 8'h08;
    step_chk("R9");
    sthr = 8'd254;
    step_chk("R9");
    mthr = 8'd1; pend = 8'h80;
    step_chk("R9");

    // map A: mixed modes, tie on 1/5 levels, disabled line 6, reserved 2
    wr(0, 1'b1, 2'b11, 8'd40);
    wr(1, 1'b1, 2'b01, 8'd120);
    wr(2, 1'b1, 2'b10, 8'd220);
    wr(3, 1'b1, 2'b01, 8'd60);
    wr(4, 1'b1, 2'b11, 8'd180);
    wr(5, 1'b1, 2'b01, 8'd120);
    wr(6, 1'b0, 2'b11, 8'd255);
    wr(7, 1'b1, 2'b11, 8'd180);
    sweep("R7 R8 R9 map A");
    // map B: software/timer placement plus extra lines
    wr(0, 1'b1, 2'b01, 8'd255);
    wr(1, 1'b1, 2'b11, 8'd101);
    wr(2, 1'b1, 2'b01, 8'd51);
    wr(3, 1'b1, 2'b01, 8'd255);
    wr(4, 1'b1, 2'b00, 8'd10);
    wr(5, 1'b0, 2'b01, 8'd255);
    wr(6, 1'b1, 2'b11, 8'd101);
    wr(7, 1'b1, 2'b11, 8'd1);
    sweep("R3 R4 R5 R6 R11 map B");

    summary();
    $finish;
  end
endmodule